// File: doc/BRIEF.md
# SD/MMC Card Clock Generator

This block produces the clock that drives a memory card bus from a faster master clock. A single control word, written through a one-cycle write strobe, holds an 8-bit divide value, an enable, a pass-through selector, a power-save selector, a flow-control enable and two bus-width selectors. The block turns these into a card clock output, a one-cycle strobe that marks the master cycle just before every card-clock rising edge, and a bus-width code for the data path.

Two divide formulas are available and are fixed at build time by a parameter. In the even formula the card period is 2*(N+1) master cycles with an even duty cycle. In the compact formula it is N+2 master cycles, high for the lower half. The clock never produces a shortened pulse. A period that has begun always runs to its end with the divide value it started with. Stop requests (enable clear, power-save with an idle bus, a flow-control stall) take effect at the next period boundary. The clock then parks low until the request goes away.

The command and data engines use the strobe to launch and capture bits. They can stop the clock through the flow-control inputs when their FIFO cannot keep up.

Top module: `sdclk_gen`

## Requirements
- R1: After reset the control word is all zero: the card clock is low, the strobe is low and the width code is 0.
- R2: With DIV_MODE=0 and the enable bit (bit 8) set, the card clock period is 2*(N+1) master cycles, high for N+1 of them, where N is bits 7:0.
- R3: With DIV_MODE=1 and the enable bit set, the card clock period is N+2 master cycles, high for floor((N+2)/2) of them.
- R4: With the enable bit clear, the card clock stays low and no strobe is produced once any period already under way has ended.
- R5: With the pass-through bit (bit 10) and the enable bit set, the card clock follows the master clock, the strobe is high every master cycle and the divide value has no effect.
- R6: With the power-save bit (bit 9) set, the clock parks low while bus_active is low and runs at its programmed rate while bus_active is high.
- R7: With the flow-control bit (bit FC_BIT, default 13) set, the clock parks low while tx_empty or rx_full is high. With that bit clear, those two inputs have no effect on the clock.
- R8: The width code is {bit 12, bit 11} of the last written word: 2'b01 selects the 4-bit bus, 2'b10 the 8-bit bus. It updates in the cycle after the write.
- R9: A new divide value written during a period does not alter that period. It applies from the next period on.
- R10: The strobe lasts one master cycle and is high in exactly the cycle before each card-clock rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | REG_W | Control word value |
| bus_active | input | 1 | Command or data transfer in progress (used by power-save) |
| tx_empty | input | 1 | Transmit FIFO empty (flow-control stall) |
| rx_full | input | 1 | Receive FIFO full (flow-control stall) |
| card_clk | output | 1 | Card clock |
| clk_strobe | output | 1 | High in the master cycle before a card-clock rising edge |
| bus_width | output | 2 | Width code for the data path |

## Verification
The assertions assume that cfg_we, bus_active, tx_empty and rx_full change only away from the rising master edge. They also assume that pass-through is never selected while the divided clock is high, because the pass-through gate is armed only from a parked divider. The bench drives every input on the falling edge or in mid-cycle after sampling. It switches into pass-through only after the divided clock has had time to park. Outputs are sampled five nanoseconds after the rising edge, plus once after the falling edge to see the low half of the pass-through clock.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  localparam int DIV_W   = 8;
  localparam int POS_EN  = 8;
  localparam int POS_PS  = 9;
  localparam int POS_BY  = 10;
  localparam int POS_W4  = 11;
  localparam int POS_W8  = 12;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             en;
    logic             pwrsave;
    logic             bypass;
    logic             flowctl;
    logic [1:0]       width;
  } sdclk_cfg_t;
endpackage

// File: rtl/sdclk_cfg_reg.sv
module sdclk_cfg_reg
  import sdclk_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int FC_BIT = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output sdclk_cfg_t       cfg
);
  sdclk_cfg_t cfg_q;
  sdclk_cfg_t cfg_d;
  logic       unused_bits;

  always_comb begin
    cfg_d.div     = wdata[DIV_W-1:0];
    cfg_d.en      = wdata[POS_EN];
    cfg_d.pwrsave = wdata[POS_PS];
    cfg_d.bypass  = wdata[POS_BY];
    cfg_d.flowctl = wdata[FC_BIT];
    cfg_d.width   = {wdata[POS_W8], wdata[POS_W4]};
  end

  assign unused_bits = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg_q <= '0;
    else if (we) cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/sdclk_gate.sv
module sdclk_gate
  import sdclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  sdclk_cfg_t cfg,
  input  logic       bus_active,
  input  logic       tx_empty,
  input  logic       rx_full,
  input  logic       div_parked,
  output logic       run_div,
  output logic       byp_gate
);
  logic stall;
  logic allow;

  always_comb begin
    stall   = (cfg.flowctl && (tx_empty || rx_full)) ||
              (cfg.pwrsave && !bus_active);
    allow   = cfg.en && !stall;
    run_div = allow && !cfg.bypass;
  end

  // Re-armed only while the master clock is low, so the gated clock
  // cannot be cut in its high half.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) byp_gate <= 1'b0;
    else        byp_gate <= allow && cfg.bypass && div_parked;
  end
endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider
  import sdclk_pkg::*;
#(
  parameter int DIV_MODE = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             run,
  output logic             strobe,
  output logic             parked,
  output logic             clk_q
);
  localparam int CW = DIV_W + 2;

  logic [DIV_W-1:0] div_act;
  logic [CW-1:0]    cnt;
  logic [CW-1:0]    cnt_inc;
  logic [CW-1:0]    last_idx;
  logic [CW-1:0]    hi_len;
  logic             at_last;

  generate
    if (DIV_MODE == 0) begin : g_even
      assign last_idx = {1'b0, div_act, 1'b1};
      assign hi_len   = {2'b00, div_act} + CW'(1);
    end else begin : g_compact
      assign last_idx = {2'b00, div_act} + CW'(1);
      assign hi_len   = ({2'b00, div_act} + CW'(2)) >> 1;
    end
  endgenerate

  assign cnt_inc = cnt + CW'(1);
  assign at_last = (cnt == last_idx);
  assign strobe  = run && (parked || at_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_act <= '0;
      cnt     <= '0;
      parked  <= 1'b1;
      clk_q   <= 1'b0;
    end else if (strobe) begin
      div_act <= div;
      cnt     <= '0;
      parked  <= 1'b0;
      clk_q   <= 1'b1;
    end else if (!parked) begin
      if (at_last) begin
        parked <= 1'b1;
        clk_q  <= 1'b0;
      end else begin
        cnt   <= cnt_inc;
        clk_q <= (cnt_inc < hi_len);
      end
    end
  end
endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
  import sdclk_pkg::*;
#(
  parameter int REG_W    = 16,
  parameter int FC_BIT   = 13,
  parameter int DIV_MODE = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic             bus_active,
  input  logic             tx_empty,
  input  logic             rx_full,
  output logic             card_clk,
  output logic             clk_strobe,
  output logic [1:0]       bus_width
);
  sdclk_cfg_t cfg;
  logic       run_div;
  logic       byp_gate;
  logic       div_strobe;
  logic       div_parked;
  logic       div_clk_q;
  logic       en_q;

  sdclk_cfg_reg #(.REG_W(REG_W), .FC_BIT(FC_BIT)) u_reg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .cfg(cfg)
  );

  sdclk_gate u_gate (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .bus_active(bus_active),
    .tx_empty(tx_empty), .rx_full(rx_full), .div_parked(div_parked),
    .run_div(run_div), .byp_gate(byp_gate)
  );

  sdclk_divider #(.DIV_MODE(DIV_MODE)) u_div (
    .clk(clk), .rst_n(rst_n), .div(cfg.div), .run(run_div),
    .strobe(div_strobe), .parked(div_parked), .clk_q(div_clk_q)
  );

  assign en_q       = cfg.en;
  assign card_clk   = byp_gate ? clk : div_clk_q;
  assign clk_strobe = div_strobe || byp_gate;
  assign bus_width  = cfg.width;
endmodule

// File: rtl/sdclk_gen_chk.sv
module sdclk_gen_chk #(
  parameter int REG_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [REG_W-1:0] cfg_wdata,
  input logic             en_q,
  input logic             div_clk,
  input logic             byp_gate,
  input logic             clk_strobe,
  input logic [1:0]       bus_width
);
  assert_strobe_then_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_strobe && !byp_gate) |=> div_clk);

  assert_rise_after_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(div_clk) |-> $past(clk_strobe));

  assert_off_stays_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !div_clk) |=> !div_clk);

  assert_bypass_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    byp_gate |-> !div_clk);

  assert_width_follows_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> bus_width == $past({cfg_wdata[12], cfg_wdata[11]}));
endmodule

bind sdclk_gen sdclk_gen_chk #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .en_q(en_q), .div_clk(div_clk_q), .byp_gate(byp_gate),
  .clk_strobe(clk_strobe), .bus_width(bus_width)
);

// File: tb/sdclk_gen_bench.sv
module sdclk_gen_bench;
  localparam logic [15:0] EN = 16'h0100, PS = 16'h0200, BY = 16'h0400,
                          W4 = 16'h0800, W8 = 16'h1000, FC = 16'h2000;
  localparam int NV = 6;
  localparam int V_DIV [NV] = '{0, 1, 2, 5, 7, 255};
  localparam int V_PA  [NV] = '{2, 4, 6, 12, 16, 512};
  localparam int V_HA  [NV] = '{1, 2, 3, 6, 8, 256};
  localparam int V_PB  [NV] = '{2, 3, 4, 7, 9, 257};
  localparam int V_HB  [NV] = '{1, 1, 2, 3, 4, 128};

  logic clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic bus_active = 1'b1, tx_empty = 1'b0, rx_full = 1'b0;
  logic card_a, stb_a, card_b, stb_b;
  logic [1:0] w_a, w_b;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  sdclk_gen #(.DIV_MODE(0)) u_sdclk_gen (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .bus_active(bus_active), .tx_empty(tx_empty), .rx_full(rx_full),
    .card_clk(card_a), .clk_strobe(stb_a), .bus_width(w_a));

  sdclk_gen #(.DIV_MODE(1)) u_sdclk_gen_b (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .bus_active(bus_active), .tx_empty(tx_empty), .rx_full(rx_full),
    .card_clk(card_b), .clk_strobe(stb_b), .bus_width(w_b));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #5;
  endtask

  task automatic wr(input logic [15:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic measure(input bit sel_b, output int per, output int hi);
    per = 0; hi = 0;
    for (int i = 0; i < 2000; i++) begin
      step();
      if (sel_b ? stb_b : stb_a) break;
    end
    for (int i = 0; i < 2000; i++) begin
      step();
      per++;
      if (sel_b ? card_b : card_a) hi++;
      if (sel_b ? stb_b : stb_a) break;
    end
  endtask

  task automatic quiet(input string req, input int n);
    int act = 0;
    for (int i = 0; i < n; i++) begin
      step();
      act += int'(card_a) + int'(stb_a) + int'(card_b) + int'(stb_b);
    end
    chk(req, act, 0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    int per, hi;
    repeat (3) @(negedge clk);
    #5;
    chk("R1 card_clk", int'(card_a), 0);
    chk("R1 strobe", int'(stb_a), 0);
    chk("R1 width", int'(w_a), 0);
    rst_n = 1'b1;
    quiet("R1 idle after reset", 10);

    for (int v = 0; v < NV; v++) begin
      wr(EN | 16'(V_DIV[v]));
      measure(1'b0, per, hi);
      chk("R2 period", per, V_PA[v]);
      chk("R2 high", hi, V_HA[v]);
      measure(1'b1, per, hi);
      chk("R3 period", per, V_PB[v]);
      chk("R3 high", hi, V_HB[v]);
    end

    // R4: enable clear parks the clock low
    wr(16'h0003);
    repeat (600) step();
    quiet("R4 disabled", 30);

    // R9: write during a running period
    wr(EN | 16'd3);
    per = 0; hi = 0;
    for (int i = 0; i < 100; i++) begin step(); if (stb_a) break; end
    cfg_wdata = EN; cfg_we = 1'b1;
    for (int i = 0; i < 100; i++) begin
      step(); cfg_we = 1'b0;
      per++; if (card_a) hi++;
      if (stb_a) break;
    end
    chk("R9 old period kept", per, 8);
    chk("R9 old high kept", hi, 4);
    measure(1'b0, per, hi);
    chk("R9 new period", per, 2);

    // R5: pass-through
    wr(EN | BY | 16'd9);
    repeat (30) step();
    chk("R5 card high phase A", int'(card_a), 1);
    chk("R5 strobe A", int'(stb_a), 1);
    chk("R5 card high phase B", int'(card_b), 1);
    @(negedge clk); #5;
    chk("R5 card low phase A", int'(card_a), 0);
    chk("R5 card low phase B", int'(card_b), 0);

    // R6: power-save
    bus_active = 1'b0;
    wr(EN | PS | 16'd1);
    repeat (30) step();
    quiet("R6 idle bus parks", 20);
    @(negedge clk); bus_active = 1'b1;
    measure(1'b0, per, hi);
    chk("R6 resume period", per, 4);

    // R7: flow control
    @(negedge clk); tx_empty = 1'b1;
    wr(EN | FC | 16'd1);
    repeat (30) step();
    quiet("R7 tx empty stalls", 20);
    @(negedge clk); tx_empty = 1'b0; rx_full = 1'b1;
    repeat (5) step();
    quiet("R7 rx full stalls", 20);
    wr(EN | 16'd1);
    measure(1'b0, per, hi);
    chk("R7 stall inputs ignored", per, 4);
    @(negedge clk); rx_full = 1'b0;

    // R8: width code
    wr(EN | W4);
    chk("R8 4-bit", int'(w_a), 1);
    wr(EN | W8);
    chk("R8 8-bit", int'(w_b), 2);

    // R10: strobe exactly one cycle before each rise
    wr(EN | 16'd2);
    repeat (20) step();
    per = 0;
    for (int i = 0; i < 60; i++) begin
      logic s_prev;
      s_prev = stb_a;
      hi = int'(card_a);
      step();
      if (card_a && hi == 0 && !s_prev) per++;
      if (s_prev && !card_a) per++;
    end
    chk("R10 strobe/rise pairing", per, 0);

    summary();
  end
endmodule